// File: doc/BRIEF.md
# Receive FIFO Watermark Status Generator

This block sits beside a receive packet FIFO and builds the flag and count fields that go into each receive completion word. It samples the FIFO's byte occupancy, its empty flag and the number of packets that no channel has claimed yet. It samples them only in the cycle when a copy-out finishes, and holds the result until the next finish. The flags are: FIFO empty, occupancy over the high watermark, and a hysteresis flag that reports "has stayed low".

On each finished copy it also raises one-cycle interrupt events: a DMA-done event always, and an empty event when the FIFO is empty at that moment. The events are unmasked; masking and aggregation belong to the interrupt controller that receives them.

Top module: `rx_wm_status`

## Requirements
- R1: After reset, `status_word` is zero except bit 26, which is 1. `flag_empty`, `flag_high`, `irq_dma`, `irq_empty` are 0, `flag_not_high` is 1 and `pkt_count` is 0.
- R2: One cycle after a cycle with `copy_done`=1, `flag_empty` and `status_word[28]` equal the `fifo_empty` value sampled in that cycle.
- R3: One cycle after `copy_done`, `flag_high` and `status_word[27]` are 1 exactly when the sampled `occ_bytes` is strictly greater than `high_mark`. Equality gives 0.
- R4: On `copy_done` with `occ_bytes` < `low_mark` and `occ_bytes` <= `high_mark`, the low flag (`flag_not_high`, `status_word[26]`) becomes 1 one cycle later.
- R5: On `copy_done` with `occ_bytes` > `high_mark`, the low flag becomes 0 one cycle later.
- R6: On `copy_done` with `low_mark` <= `occ_bytes` <= `high_mark`, the low flag keeps its previous value.
- R7: When `occ_bytes` is both below `low_mark` and above `high_mark` (marks programmed inverted), the high test wins and the low flag becomes 0.
- R8: One cycle after `copy_done`, `pkt_count` and `status_word[CNT_W-1:0]` equal the sampled `unclaimed_pkts`.
- R9: In cycles without `copy_done`, changes on the other inputs have no effect: all status outputs keep their values.
- R10: `irq_dma` is 1 for exactly the cycle after each cycle with `copy_done`=1, and 0 otherwise.
- R11: `irq_empty` is 1 exactly in the cycle after a `copy_done` cycle in which `fifo_empty` was 1. It is never 1 without `irq_dma`.
- R12: `status_word` bits 31:29 and bits 25:CNT_W are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| occ_bytes | input | OCC_W | FIFO occupancy in bytes |
| fifo_empty | input | 1 | FIFO holds no packet |
| unclaimed_pkts | input | CNT_W | Packets not yet claimed by any channel |
| high_mark | input | OCC_W | High watermark in bytes |
| low_mark | input | OCC_W | Low mark in bytes |
| copy_done | input | 1 | One copy-out finished this cycle |
| status_word | output | 32 | Merged status: bit 28 empty, bit 27 high, bit 26 low flag, count in low bits |
| pkt_count | output | CNT_W | Registered unclaimed packet count |
| flag_empty | output | 1 | Registered empty flag |
| flag_high | output | 1 | Registered over-watermark flag |
| flag_not_high | output | 1 | Hysteresis low flag |
| irq_dma | output | 1 | DMA-done event pulse |
| irq_empty | output | 1 | FIFO-empty event pulse |

## Verification
The bench tries occupancy at exactly the high mark and one byte either side of it, to show that the high comparison is strict. It walks occupancy through the band between the marks in both directions, to show that the low flag holds inside the band rather than following one comparator. It also programs the marks inverted, so both tests fire at once and the order of the two tests becomes visible.

Seeded random copies with random marks, counts and empty flags are then checked against a bench model. Idle stretches with changing inputs are mixed in, to confirm that only the strobe samples. Back-to-back strobes are included, to confirm that each one yields its own event pulse.

// File: rtl/rxwm_pkg.sv
package rxwm_pkg;
   localparam int unsigned WORD_W      = 32;
   localparam int unsigned EMPTY_BIT   = 28;
   localparam int unsigned HIGH_BIT    = 27;
   localparam int unsigned NOTHIGH_BIT = 26;
   localparam int unsigned FIELD_LSB   = NOTHIGH_BIT;

   typedef struct packed {
      logic empty;
      logic high;
      logic not_high;
   } rxwm_flags_t;

   localparam rxwm_flags_t FLAGS_RESET = '{empty: 1'b0, high: 1'b0, not_high: 1'b1};
endpackage

// File: rtl/rxwm_cmp.sv
module rxwm_cmp #(
   parameter int unsigned OCC_W = 16
) (
   input  logic [OCC_W-1:0] occ,
   input  logic [OCC_W-1:0] hi_mark,
   input  logic [OCC_W-1:0] lo_mark,
   output logic             above_hi,
   output logic             below_lo
);
   always_comb begin
      above_hi = (occ > hi_mark);
      below_lo = (occ < lo_mark);
   end
endmodule

// File: rtl/rxwm_hyst.sv
module rxwm_hyst (
   input  logic clk,
   input  logic rst_n,
   input  logic upd,
   input  logic above_hi,
   input  logic below_lo,
   output logic low_flag
);
   logic nxt;

   always_comb begin
      nxt = low_flag;
      if (below_lo) nxt = 1'b1;
      if (above_hi) nxt = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   low_flag <= 1'b1;
      else if (upd) low_flag <= nxt;
   end
endmodule

// File: rtl/rxwm_evt.sv
module rxwm_evt (
   input  logic clk,
   input  logic rst_n,
   input  logic done,
   input  logic empty,
   output logic dma_pulse,
   output logic empty_pulse
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dma_pulse   <= 1'b0;
         empty_pulse <= 1'b0;
      end else begin
         dma_pulse   <= done;
         empty_pulse <= done & empty;
      end
   end
endmodule

// File: rtl/rx_wm_status.sv
module rx_wm_status
   import rxwm_pkg::*;
#(
   parameter int unsigned OCC_W = 16,
   parameter int unsigned CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [OCC_W-1:0] occ_bytes,
   input  logic             fifo_empty,
   input  logic [CNT_W-1:0] unclaimed_pkts,
   input  logic [OCC_W-1:0] high_mark,
   input  logic [OCC_W-1:0] low_mark,
   input  logic             copy_done,
   output logic [31:0]      status_word,
   output logic [CNT_W-1:0] pkt_count,
   output logic             flag_empty,
   output logic             flag_high,
   output logic             flag_not_high,
   output logic             irq_dma,
   output logic             irq_empty
);
   localparam int unsigned PAD_W = FIELD_LSB - CNT_W;

   generate
      if (OCC_W < 1 || OCC_W > 32) begin : g_bad_occ
         $error("rx_wm_status: OCC_W must be 1..32");
      end
      if (CNT_W < 1 || CNT_W > FIELD_LSB) begin : g_bad_cnt
         $error("rx_wm_status: CNT_W must be 1..26");
      end
   endgenerate

   logic        above_hi, below_lo, low_flag;
   rxwm_flags_t flags_q;
   logic [CNT_W-1:0] cnt_q;

   rxwm_cmp #(.OCC_W(OCC_W)) u_cmp (
      .occ      (occ_bytes),
      .hi_mark  (high_mark),
      .lo_mark  (low_mark),
      .above_hi (above_hi),
      .below_lo (below_lo)
   );

   rxwm_hyst u_hyst (
      .clk      (clk),
      .rst_n    (rst_n),
      .upd      (copy_done),
      .above_hi (above_hi),
      .below_lo (below_lo),
      .low_flag (low_flag)
   );

   rxwm_evt u_evt (
      .clk         (clk),
      .rst_n       (rst_n),
      .done        (copy_done),
      .empty       (fifo_empty),
      .dma_pulse   (irq_dma),
      .empty_pulse (irq_empty)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags_q.empty <= FLAGS_RESET.empty;
         flags_q.high  <= FLAGS_RESET.high;
         cnt_q         <= '0;
      end else if (copy_done) begin
         flags_q.empty <= fifo_empty;
         flags_q.high  <= above_hi;
         cnt_q         <= unclaimed_pkts;
      end
   end

   always_comb flags_q.not_high = low_flag;

   assign flag_empty    = flags_q.empty;
   assign flag_high     = flags_q.high;
   assign flag_not_high = flags_q.not_high;
   assign pkt_count     = cnt_q;

   generate
      if (PAD_W > 0) begin : g_pad
         assign status_word = {3'b000, flags_q, {PAD_W{1'b0}}, cnt_q};
      end else begin : g_nopad
         assign status_word = {3'b000, flags_q, cnt_q};
      end
   endgenerate
endmodule

// File: rtl/rxwm_status_chk.sv
module rxwm_status_chk #(
   parameter int unsigned OCC_W = 16,
   parameter int unsigned CNT_W = 12
) (
   input logic             clk,
   input logic             rst_n,
   input logic [OCC_W-1:0] occ_bytes,
   input logic             fifo_empty,
   input logic [CNT_W-1:0] unclaimed_pkts,
   input logic [OCC_W-1:0] high_mark,
   input logic [OCC_W-1:0] low_mark,
   input logic             copy_done,
   input logic [31:0]      status_word,
   input logic [CNT_W-1:0] pkt_count,
   input logic             flag_empty,
   input logic             flag_high,
   input logic             flag_not_high,
   input logic             irq_dma,
   input logic             irq_empty
);
   // R2
   empty_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
      copy_done |=> (flag_empty == $past(fifo_empty)) && (status_word[28] == flag_empty));
   // R3
   high_strict_chk: assert property (@(posedge clk) disable iff (!rst_n)
      copy_done |=> flag_high == ($past(occ_bytes) > $past(high_mark)));
   // R4
   low_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (copy_done && occ_bytes < low_mark && occ_bytes <= high_mark) |=> flag_not_high);
   // R5
   low_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (copy_done && occ_bytes > high_mark) |=> !flag_not_high);
   // R6
   low_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (copy_done && occ_bytes >= low_mark && occ_bytes <= high_mark) |=> $stable(flag_not_high));
   // R8
   count_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
      copy_done |=> pkt_count == $past(unclaimed_pkts));
   // R9
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !copy_done |=> $stable(status_word));
   // R10
   dma_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      copy_done |=> irq_dma);
   // R10
   dma_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !copy_done |=> !irq_dma);
   // R11
   empty_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_empty |-> irq_dma);
   // R12
   reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      status_word[31:29] == 3'b000);
endmodule

bind rx_wm_status rxwm_status_chk #(.OCC_W(OCC_W), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .occ_bytes(occ_bytes), .fifo_empty(fifo_empty),
   .unclaimed_pkts(unclaimed_pkts), .high_mark(high_mark), .low_mark(low_mark),
   .copy_done(copy_done), .status_word(status_word), .pkt_count(pkt_count),
   .flag_empty(flag_empty), .flag_high(flag_high), .flag_not_high(flag_not_high),
   .irq_dma(irq_dma), .irq_empty(irq_empty)
);

// File: tb/sim_rx_wm_status.sv
`timescale 1ns/1ps
module sim_rx_wm_status;
   localparam int OCC_W = 16;
   localparam int CNT_W = 12;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [OCC_W-1:0] occ_bytes = '0;
   logic             fifo_empty = 1'b0;
   logic [CNT_W-1:0] unclaimed_pkts = '0;
   logic [OCC_W-1:0] high_mark = '0;
   logic [OCC_W-1:0] low_mark = '0;
   logic             copy_done = 1'b0;
   logic [31:0]      status_word;
   logic [CNT_W-1:0] pkt_count;
   logic             flag_empty, flag_high, flag_not_high, irq_dma, irq_empty;

   int n_cmp = 0;
   int n_bad = 0;
   bit m_low = 1'b1;
   int unsigned seed_v;

   always #2 clk = ~clk;

   rx_wm_status #(.OCC_W(OCC_W), .CNT_W(CNT_W)) u0 (.*);

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_word(bit e, bit h, bit nh, logic [CNT_W-1:0] c);
      return {3'b000, e, h, nh, 14'd0, c};
   endfunction

   // one copy: strobe for one cycle, check status and event after it
   task automatic do_copy(input logic [OCC_W-1:0] occ, input logic [OCC_W-1:0] hi,
                          input logic [OCC_W-1:0] lo, input bit emp,
                          input logic [CNT_W-1:0] cnt, input bit back2back);
      bit eh;
      @(negedge clk);
      occ_bytes = occ; high_mark = hi; low_mark = lo;
      fifo_empty = emp; unclaimed_pkts = cnt; copy_done = 1'b1;
      if (occ < lo) m_low = 1'b1;
      if (occ > hi) m_low = 1'b0;
      eh = (occ > hi);
      @(negedge clk);
      if (!back2back) copy_done = 1'b0;
      check("R2 empty flag", {31'd0, flag_empty}, {31'd0, emp});
      check("R3 high flag", {31'd0, flag_high}, {31'd0, eh});
      check("R4/R5/R6/R7 low flag", {31'd0, flag_not_high}, {31'd0, m_low});
      check("R8 count", {20'd0, pkt_count}, {20'd0, cnt});
      check("R12 word", status_word, exp_word(emp, eh, m_low, cnt));
      check("R10 dma pulse", {31'd0, irq_dma}, 32'd1);
      check("R11 empty pulse", {31'd0, irq_empty}, {31'd0, emp});
   endtask

   task automatic idle_check(input int cycles);
      logic [31:0] w0;
      @(negedge clk);
      copy_done = 1'b0;
      @(negedge clk);
      w0 = status_word;
      for (int i = 0; i < cycles; i++) begin
         occ_bytes = OCC_W'($urandom_range(0, 1023));
         high_mark = OCC_W'($urandom_range(0, 1023));
         low_mark = OCC_W'($urandom_range(0, 1023));
         fifo_empty = 1'($urandom_range(0, 1));
         unclaimed_pkts = CNT_W'($urandom);
         @(negedge clk);
         check("R9 hold", status_word, w0);
         check("R10 no dma", {31'd0, irq_dma}, 32'd0);
         check("R11 no empty evt", {31'd0, irq_empty}, 32'd0);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      seed_v = $urandom(32'h5eed_0042);
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 word", status_word, exp_word(0, 0, 1, '0));
      check("R1 irq", {30'd0, irq_dma, irq_empty}, 32'd0);
      check("R1 flags", {29'd0, flag_empty, flag_high, flag_not_high}, 32'd1);
      rst_n = 1'b1;
      @(negedge clk);

      // R3 strict comparison around the mark
      do_copy(16'd500, 16'd500, 16'd100, 0, 12'd3, 0);
      do_copy(16'd501, 16'd500, 16'd100, 0, 12'd4, 0);
      do_copy(16'd499, 16'd500, 16'd100, 0, 12'd5, 0);
      // R6 in band holds 0, then R4 drop below low sets, then R6 holds 1
      do_copy(16'd300, 16'd500, 16'd100, 0, 12'd6, 0);
      check("R6 band keeps cleared", {31'd0, flag_not_high}, 32'd0);
      do_copy(16'd99, 16'd500, 16'd100, 0, 12'd1, 0);
      check("R4 below low sets", {31'd0, flag_not_high}, 32'd1);
      do_copy(16'd100, 16'd500, 16'd100, 0, 12'd2, 0);
      check("R6 band keeps set", {31'd0, flag_not_high}, 32'd1);
      do_copy(16'd500, 16'd500, 16'd100, 0, 12'd2, 0);
      check("R6 at high mark keeps set", {31'd0, flag_not_high}, 32'd1);
      // R7 inverted marks: both tests true, flag cleared
      do_copy(16'd200, 16'd100, 16'd300, 0, 12'd7, 0);
      check("R7 high test wins", {31'd0, flag_not_high}, 32'd0);
      // R2/R11 empty FIFO
      do_copy(16'd0, 16'd500, 16'd100, 1, 12'd0, 0);
      idle_check(6);
      // R10 back-to-back strobes
      do_copy(16'd600, 16'd500, 16'd100, 1, 12'd9, 1);
      do_copy(16'd50, 16'd500, 16'd100, 0, 12'd8, 0);
      @(negedge clk);
      check("R10 pulse ends", {31'd0, irq_dma}, 32'd0);

      for (int k = 0; k < 400; k++) begin
         logic [OCC_W-1:0] hi, lo;
         hi = OCC_W'($urandom_range(0, 1023));
         lo = OCC_W'($urandom_range(0, 1023));
         do_copy(OCC_W'($urandom_range(0, 1023)), hi, lo, 1'($urandom_range(0, 1)),
                 CNT_W'($urandom), 1'($urandom_range(0, 3) == 0));
         if ($urandom_range(0, 9) == 0) idle_check(3);
      end
      idle_check(2);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule